// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects 32 external interrupt request lines and presents one request and vector to a CPU. The vectors are fixed: line n always arrives as vector 32+n. Priority is also fixed: a larger vector always wins. A request can preempt the interrupt in service only when its vector is higher than every vector already in service. Lower requests wait until software writes end-of-interrupt. The controller then drops the highest in-service bit and offers the best remaining request.

Software uses a small 32-bit register bus. Each line's entry holds a mask bit and a trigger-mode bit. Software reaches an entry through a select register and a data window, and the select value is a scrambled form of the line number. Other registers give the in-service bits, the end-of-interrupt strobe, a task-priority threshold, a local timer entry that takes over one of lines 0 to 15, and a timer initial-count store. A delivery state machine hands requests to the CPU. It has three states. ST_IDLE goes to ST_OFFER when a deliverable request exists. ST_OFFER goes to ST_GAP on an acknowledge, and back to ST_IDLE if the request goes away. ST_GAP always returns to ST_IDLE after one cycle.

Top module: `fpvic_top`

## Requirements
- R1: Line n always delivers vector 32+n, shown on `irq_vec` while `irq_o` is high. `irq_vec` is 0 while `irq_o` is low.
- R2: Among deliverable requests the highest vector is offered. While interrupts are in service, a request is offered only if its vector is above the highest in-service vector.
- R3: Lower requests stay pending while a higher vector is in service. A write to end-of-interrupt (word offset 0x0C) clears only the highest in-service bit, and the best remaining pending unmasked request is then offered.
- R4: The in-service register at 0x08 has bit k set while vector 32+k is in service. It reads 0 when nothing is in service.
- R5: The select register is at 0x00 and the data window at 0x04. Line n is selected by ((n & 15) << 1) | ((n >> 4) << 6). A select with bit 0 or bit 5 set makes the window read 0 and ignore writes.
- R6: Entry bit 16 is the mask. A masked line is never offered, and a rising edge seen while masked is not latched. After reset every entry reads 0x0001_0000.
- R7: The timer entry is at 0x14, with bits 3:0 holding the claimed line and bit 16 its mask. It reads 0x0001_0000 after reset. The claimed line is fed by `timer_evt` as an edge source gated by the timer mask, and that line's external input is ignored.
- R8: The task-priority register (0x10, bits 7:0) and the timer count register (0x18, 32 bits) read 0 after reset and read back what was written. An end-of-interrupt write with nothing in service leaves the in-service register at 0.
- R9: Entry bit 15 selects the trigger mode: 0 is edge, 1 is level. An edge line latches pending on a rising input. A level line is pending while its input is high and it is unmasked, and it is offered again after end-of-interrupt if its input is still high.
- R10: Window writes to bits other than 16 and 15 are ignored, and those bits read 0.
- R11: A request is offered only if its vector bits 7:4 are greater than task-priority bits 7:4. A blocked edge request stays pending.
- R12: An `int_ack` pulse while `irq_o` is high moves the offered vector into in-service and clears its edge-pending bit. `irq_o` is low in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high |
| bus_addr | input | 5 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_in | input | 32 | External request lines |
| timer_evt | input | 1 | Local timer event, edge source |
| int_ack | input | 1 | CPU acknowledge pulse |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector of the offered request |

## Verification
Corrupted pending or in-service state shows up at the ports within a few cycles of the next acknowledge or end-of-interrupt. It appears as a wrong vector, a request that should be held but is offered, or an in-service readback with the wrong bit set. A mistake in the select decode or the mask reset appears on the first window read, or as an interrupt from a line that should be silent. Errors in the nesting order only show after two levels of preemption have been unwound, so the bench nests requests and then checks the in-service register after each end-of-interrupt.

// File: rtl/fpvic_pkg.sv
package fpvic_pkg;
    timeunit 1ns; timeprecision 1ps;

    localparam int unsigned FPV_LINES     = 32;
    localparam int unsigned FPV_IDX_W     = $clog2(FPV_LINES);
    localparam int unsigned FPV_VBASE     = 32;
    localparam int unsigned FPV_VEC_W     = 8;
    localparam int unsigned FPV_TMR_LINES = 16;
    localparam int unsigned FPV_TMR_W     = $clog2(FPV_TMR_LINES);
    localparam int unsigned FPV_SEL_W     = 8;
    localparam int unsigned FPV_CLS_W     = 4;
    localparam int unsigned ENT_MASK_BIT  = 16;
    localparam int unsigned ENT_TRIG_BIT  = 15;

    typedef enum logic [1:0] {ST_IDLE, ST_OFFER, ST_GAP} dlv_state_t;

    typedef enum logic [2:0] {
        RG_SEL  = 3'd0,
        RG_WIN  = 3'd1,
        RG_INSV = 3'd2,
        RG_EOI  = 3'd3,
        RG_TPRI = 3'd4,
        RG_TMRV = 3'd5,
        RG_TMRC = 3'd6
    } reg_idx_t;

    // index of the most significant set bit, 0 when none is set
    function automatic logic [FPV_IDX_W-1:0] top_bit(input logic [FPV_LINES-1:0] v);
        logic [FPV_IDX_W-1:0] r;
        r = '0;
        for (int i = 0; i < int'(FPV_LINES); i++)
            if (v[i]) r = FPV_IDX_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/fpvic_regs.sv
module fpvic_regs
    import fpvic_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [FPV_LINES-1:0] insv_i,
    output logic [FPV_LINES-1:0] mask_o,
    output logic [FPV_LINES-1:0] trig_o,
    output logic [FPV_CLS_W-1:0] tpr_cls_o,
    output logic [FPV_TMR_W-1:0] tmr_line_o,
    output logic                 tmr_mask_o,
    output logic                 eoi_o
);
    timeunit 1ns; timeprecision 1ps;

    localparam int LINE_W = FPV_SEL_W - 2;

    logic [FPV_SEL_W-1:0] sel_q;
    logic [7:0]           tpri_q;
    logic [DATA_W-1:0]    tmrc_q;
    logic [FPV_TMR_W-1:0] tmr_line_q;
    logic                 tmr_mask_q;
    logic [LINE_W-1:0]    sel_line;
    logic                 sel_ok, wr, aligned;
    reg_idx_t             idx;

    assign aligned  = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:5] == '0);
    assign idx      = reg_idx_t'(bus_addr[4:2]);
    assign wr       = bus_en && bus_we && aligned;
    assign sel_line = {sel_q[7:6], sel_q[4:1]};
    assign sel_ok   = !sel_q[0] && !sel_q[5] && (sel_line < LINE_W'(FPV_LINES));
    assign eoi_o    = wr && (idx == RG_EOI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q      <= '0;
            tpri_q     <= '0;
            tmrc_q     <= '0;
            tmr_line_q <= '0;
            tmr_mask_q <= 1'b1;
        end else if (wr) begin
            case (idx)
                RG_SEL:  sel_q  <= bus_wdata[FPV_SEL_W-1:0];
                RG_TPRI: tpri_q <= bus_wdata[7:0];
                RG_TMRC: tmrc_q <= bus_wdata;
                RG_TMRV: begin
                    tmr_line_q <= bus_wdata[FPV_TMR_W-1:0];
                    tmr_mask_q <= bus_wdata[ENT_MASK_BIT];
                end
                default: ;
            endcase
        end
    end

    for (genvar n = 0; n < int'(FPV_LINES); n++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_o[n] <= 1'b1;
                trig_o[n] <= 1'b0;
            end else if (wr && idx == RG_WIN && sel_ok && sel_line == LINE_W'(n)) begin
                mask_o[n] <= bus_wdata[ENT_MASK_BIT];
                trig_o[n] <= bus_wdata[ENT_TRIG_BIT];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (idx)
                RG_SEL:  bus_rdata[FPV_SEL_W-1:0] = sel_q;
                RG_WIN:  if (sel_ok) begin
                    bus_rdata[ENT_MASK_BIT] = mask_o[sel_line[FPV_IDX_W-1:0]];
                    bus_rdata[ENT_TRIG_BIT] = trig_o[sel_line[FPV_IDX_W-1:0]];
                end
                RG_INSV: bus_rdata[FPV_LINES-1:0] = insv_i;
                RG_TPRI: bus_rdata[7:0] = tpri_q;
                RG_TMRV: begin
                    bus_rdata[FPV_TMR_W-1:0] = tmr_line_q;
                    bus_rdata[ENT_MASK_BIT]  = tmr_mask_q;
                end
                RG_TMRC: bus_rdata = tmrc_q;
                default: ;
            endcase
        end
    end

    assign tpr_cls_o  = tpri_q[7:4];
    assign tmr_line_o = tmr_line_q;
    assign tmr_mask_o = tmr_mask_q;

    // R6
    mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_o == '1));
endmodule

// File: rtl/fpvic_core.sv
module fpvic_core
    import fpvic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FPV_LINES-1:0] irq_in,
    input  logic                 timer_evt,
    input  logic [FPV_LINES-1:0] mask_i,
    input  logic [FPV_LINES-1:0] trig_i,
    input  logic [FPV_CLS_W-1:0] tpr_cls_i,
    input  logic [FPV_TMR_W-1:0] tmr_line_i,
    input  logic                 tmr_mask_i,
    input  logic                 eoi_i,
    input  logic                 ack_i,
    output logic                 deliv_o,
    output logic [FPV_IDX_W-1:0] cand_idx_o,
    output logic [FPV_LINES-1:0] insv_o
);
    timeunit 1ns; timeprecision 1ps;

    logic [FPV_LINES-1:0] src, src_prev, mask_e, trig_e, edge_p, level_p, cand, insv_q;
    logic [FPV_IDX_W-1:0] cand_idx, insv_idx;
    logic [FPV_VEC_W-1:0] cand_vec;

    for (genvar n = 0; n < int'(FPV_LINES); n++) begin : g_src
        if (n < int'(FPV_TMR_LINES)) begin : g_claimable
            logic claim;
            assign claim     = (tmr_line_i == FPV_TMR_W'(n));
            assign src[n]    = claim ? timer_evt  : irq_in[n];
            assign mask_e[n] = claim ? tmr_mask_i : mask_i[n];
            assign trig_e[n] = claim ? 1'b0       : trig_i[n];
        end else begin : g_plain
            assign src[n]    = irq_in[n];
            assign mask_e[n] = mask_i[n];
            assign trig_e[n] = trig_i[n];
        end
    end

    assign level_p  = trig_e & src & ~mask_e;
    assign cand     = (edge_p | level_p) & ~mask_e & ~insv_q;
    assign cand_idx = top_bit(cand);
    assign insv_idx = top_bit(insv_q);
    assign cand_vec = FPV_VEC_W'(FPV_VBASE) + FPV_VEC_W'(cand_idx);

    assign deliv_o = (cand != '0)
                  && ((insv_q == '0) || (cand_idx > insv_idx))
                  && (cand_vec[7:4] > tpr_cls_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_prev <= '0;
            edge_p   <= '0;
            insv_q   <= '0;
        end else begin
            logic [FPV_LINES-1:0] ins_n, edge_n;
            src_prev <= src;
            edge_n = edge_p;
            if (ack_i) edge_n[cand_idx] = 1'b0;
            edge_n = edge_n | (src & ~src_prev & ~mask_e & ~trig_e);
            edge_p <= edge_n;
            ins_n = insv_q;
            if (eoi_i && insv_q != '0) ins_n[insv_idx] = 1'b0;
            if (ack_i) ins_n[cand_idx] = 1'b1;
            insv_q <= ins_n;
        end
    end

    assign cand_idx_o = cand_idx;
    assign insv_o     = insv_q;

    // R3
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !ack_i && insv_q != '0) |=>
        ($countones(insv_q) + 1 == $past($countones(insv_q))));

    // R12
    ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> insv_q[$past(cand_idx)]);
endmodule

// File: rtl/fpvic_top.sv
module fpvic_top
    import fpvic_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [FPV_LINES-1:0] irq_in,
    input  logic                 timer_evt,
    input  logic                 int_ack,
    output logic                 irq_o,
    output logic [FPV_VEC_W-1:0] irq_vec
);
    timeunit 1ns; timeprecision 1ps;

    logic [FPV_LINES-1:0] mask_w, trig_w, insv_w;
    logic [FPV_CLS_W-1:0] tpr_cls_w;
    logic [FPV_TMR_W-1:0] tmr_line_w;
    logic                 tmr_mask_w, eoi_w, deliv_w, ack_fire;
    logic [FPV_IDX_W-1:0] cand_idx_w;
    dlv_state_t           state_q, state_n;

    fpvic_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .insv_i(insv_w), .mask_o(mask_w), .trig_o(trig_w), .tpr_cls_o(tpr_cls_w),
        .tmr_line_o(tmr_line_w), .tmr_mask_o(tmr_mask_w), .eoi_o(eoi_w)
    );

    fpvic_core u_core (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .timer_evt(timer_evt),
        .mask_i(mask_w), .trig_i(trig_w), .tpr_cls_i(tpr_cls_w),
        .tmr_line_i(tmr_line_w), .tmr_mask_i(tmr_mask_w), .eoi_i(eoi_w),
        .ack_i(ack_fire), .deliv_o(deliv_w), .cand_idx_o(cand_idx_w), .insv_o(insv_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:  if (deliv_w) state_n = ST_OFFER;
            ST_OFFER: if (!deliv_w) state_n = ST_IDLE;
                      else if (int_ack) state_n = ST_GAP;
            ST_GAP:   state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_o    = (state_q == ST_OFFER) && deliv_w;
        ack_fire = irq_o && int_ack;
        irq_vec  = irq_o ? FPV_VEC_W'(FPV_VBASE) + FPV_VEC_W'(cand_idx_w) : '0;
    end

    // R1
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_vec >= FPV_VEC_W'(FPV_VBASE)) && (irq_vec < FPV_VEC_W'(FPV_VBASE + FPV_LINES)));

    // R2
    preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && insv_w != '0) |-> (irq_vec > FPV_VEC_W'(FPV_VBASE) + FPV_VEC_W'(top_bit(insv_w))));

    // R11
    tpr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_vec[7:4] > tpr_cls_w));

    // R12
    gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && int_ack) |=> !irq_o);
endmodule

// File: tb/tb_fpvic_top.sv
module tb_fpvic_top;
    timeunit 1ns; timeprecision 1ps;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] irq_in = '0;
    logic        timer_evt = 1'b0, int_ack = 1'b0;
    logic        irq_o;
    logic [7:0]  irq_vec;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int exp_q[$];

    localparam logic [4:0] A_SEL = 5'h00, A_WIN = 5'h04, A_INSV = 5'h08, A_EOI = 5'h0C,
                           A_TPRI = 5'h10, A_TMRV = 5'h14, A_TMRC = 5'h18;

    always #2.5 clk = ~clk;

    fpvic_top dut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .timer_evt(timer_evt), .int_ack(int_ack),
        .irq_o(irq_o), .irq_vec(irq_vec));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] selof(input int n);
        return 32'(((n & 15) << 1) | ((n >> 4) << 6));
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 0;
        #1 d = bus_rdata;
        @(negedge clk);
    endtask

    task automatic ent_wr(input int n, input logic [31:0] d);
        wr(A_SEL, selof(n)); wr(A_WIN, d);
    endtask

    task automatic pulse(input int n);
        irq_in[n] = 1'b1; @(negedge clk); irq_in[n] = 1'b0;
    endtask

    task automatic idle(input int c);
        repeat (c) @(negedge clk);
    endtask

    // driver side of the scoreboard
    task automatic expect_vec(input int v);
        exp_q.push_back(v);
    endtask

    // monitor side: wait for a request, compare against the queue, acknowledge
    task automatic take(input string req);
        int w = 0;
        int e;
        while (!irq_o && w < 20) begin @(negedge clk); w++; end
        e = (exp_q.size() != 0) ? exp_q.pop_front() : -1;
        check(req, {23'b0, irq_o, irq_vec}, {23'b0, 1'b1, 8'(e)});
        if (irq_o) begin
            int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
            check("R12 irq low after ack", {31'b0, irq_o}, 32'd0);
        end
    endtask

    task automatic quiet(input string req);
        idle(6);
        check(req, {23'b0, irq_o, irq_vec}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle(3); rst_n = 1'b1; idle(2);

        // reset state
        check("R1 no irq after reset", {23'b0, irq_o, irq_vec}, 32'd0);
        rd(A_INSV, d); check("R4 insv reset", d, 32'd0);
        rd(A_TPRI, d); check("R8 tpri reset", d, 32'd0);
        rd(A_TMRC, d); check("R8 tmrc reset", d, 32'd0);
        rd(A_TMRV, d); check("R7 timer entry reset", d, 32'h0001_0000);
        wr(A_SEL, selof(5)); rd(A_WIN, d); check("R6 entry masked at reset", d, 32'h0001_0000);

        // select encoding and window
        ent_wr(16, 32'h0000_8000); rd(A_WIN, d); check("R5 line16 window", d, 32'h0000_8000);
        wr(A_SEL, 32'h1E); rd(A_WIN, d); check("R5 line15 untouched", d, 32'h0001_0000);
        wr(A_SEL, 32'h01); wr(A_WIN, 32'h0); rd(A_WIN, d); check("R5 odd select reads 0", d, 32'd0);
        wr(A_SEL, selof(1)); rd(A_WIN, d); check("R5 odd select write ignored", d, 32'h0001_0000);
        ent_wr(3, 32'hFFFE_FFFF); rd(A_WIN, d); check("R10 unsupported bits zero", d, 32'h0000_8000);
        ent_wr(3, 32'h0001_0000);

        // masked line
        pulse(5); quiet("R6 masked line silent");
        ent_wr(5, 32'h0); quiet("R6 edge lost while masked");

        // single edge delivery and EOI
        ent_wr(8, 32'h0); pulse(8);
        expect_vec(40); take("R1 line8 vector");
        rd(A_INSV, d); check("R4 insv bit8", d, 32'h0000_0100);
        wr(A_EOI, 32'h0); rd(A_INSV, d); check("R3 eoi clears", d, 32'd0);
        quiet("R12 edge pending cleared by ack");

        // simultaneous requests
        ent_wr(9, 32'h0); ent_wr(20, 32'h0);
        irq_in[9] = 1; irq_in[20] = 1; @(negedge clk); irq_in[9] = 0; irq_in[20] = 0;
        expect_vec(52); take("R2 highest first");
        quiet("R3 lower held pending");
        wr(A_EOI, 32'h0);
        expect_vec(41); take("R3 next after eoi");
        wr(A_EOI, 32'h0);

        // nesting / preemption
        pulse(9); expect_vec(41); take("R2 base level");
        pulse(20); expect_vec(52); take("R2 preempt");
        rd(A_INSV, d); check("R4 nested insv", d, 32'h0010_0200);
        wr(A_EOI, 32'h0); rd(A_INSV, d); check("R3 eoi clears highest only", d, 32'h0000_0200);
        wr(A_EOI, 32'h0); rd(A_INSV, d); check("R3 insv empty", d, 32'd0);
        wr(A_EOI, 32'h0); rd(A_INSV, d); check("R8 eoi with nothing", d, 32'd0);

        // level line
        irq_in[16] = 1; expect_vec(48); take("R9 level delivered");
        wr(A_EOI, 32'h0); expect_vec(48); take("R9 level redelivered");
        irq_in[16] = 0; wr(A_EOI, 32'h0); quiet("R9 level gone");

        // task priority
        wr(A_TPRI, 32'h20); rd(A_TPRI, d); check("R8 tpri readback", d, 32'h20);
        pulse(8); quiet("R11 class blocked");
        pulse(20); expect_vec(52); take("R11 higher class passes");
        wr(A_EOI, 32'h0); quiet("R11 still blocked");
        wr(A_TPRI, 32'h0); expect_vec(40); take("R11 blocked edge kept");
        wr(A_EOI, 32'h0);

        // timer entry
        ent_wr(4, 32'h0); wr(A_TMRV, 32'h4);
        rd(A_TMRV, d); check("R7 timer readback", d, 32'h4);
        pulse(4); quiet("R7 claimed external ignored");
        timer_evt = 1; @(negedge clk); timer_evt = 0;
        expect_vec(36); take("R7 timer vector");
        wr(A_EOI, 32'h0);
        wr(A_TMRV, 32'h0001_0004);
        timer_evt = 1; @(negedge clk); timer_evt = 0; quiet("R7 timer masked");
        wr(A_TMRC, 32'h0000_1234); rd(A_TMRC, d); check("R8 tmrc readback", d, 32'h0000_1234);

        check("scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule